// File: doc/BRIEF.md
# Compare-Match Watchdog Slot

This block is one compare slot of a counter array that shares a single free-running timer among all slots. Software loads a compare value one byte at a time, and the slot flags every cycle on which the shared timer first becomes equal to that value while the comparator is enabled. Only the slot whose index equals the designated watchdog index can also act as a watchdog. On that slot, a match that occurs while the watchdog is armed raises a one-cycle internal reset request.

Software holds the reset off in one of two ways. It can keep moving the compare value ahead of the timer. It can also disarm the watchdog before the match and arm it again afterwards. Rewriting the shared timer also prevents a match, but that changes the time base of every other slot in the array. Loading the low byte disables the comparator and loading the top byte enables it again, so a partly written value never produces a match. When the reset fires, the slot clears its compare value, its comparator enable and its watchdog enable.

Top module: `cmp_watchdog`

## Requirements
- R1: After reset, `cmp_val_o`, `cmp_en_o`, `wdog_en_o`, `match_o` and `int_rst_o` are all zero.
- R2: A write with `wr_sel_i` equal to the top lane (1 for 16 bits) stores `wr_data_i` in bits [15:8] and sets `cmp_en_o`. A `cfg_we_i` pulse with no byte write loads `cmp_en_o` from `cfg_cmp_en_i`. Each write is visible in the cycle after it is presented.
- R3: `match_o` is high for exactly one cycle. It rises in the cycle after the first cycle in which `cmp_en_o` is set and `timer_i` equals `cmp_val_o`. No match occurs while `cmp_en_o` is clear.
- R4: If `wdog_en_o` is also set in that cycle, `int_rst_o` rises for exactly one cycle, in the same cycle as `match_o`.
- R5: In the cycle `int_rst_o` is high, `cmp_val_o`, `cmp_en_o` and `wdog_en_o` are already zero. A byte write or configuration write presented in the firing cycle is discarded.
- R6: While `wdog_en_o` is clear, a match still produces `match_o` but never `int_rst_o`. Clearing the watchdog enable before the match therefore prevents the reset.
- R7: Setting `wdog_en_o` again through `cfg_we_i`/`cfg_wdog_en_i` re-arms the slot, and the next match fires the reset.
- R8: If software moves the compare value ahead of the timer before equality occurs, or returns the timer to a value below the compare value, no reset fires.
- R9: A write with `wr_sel_i` = 0 stores bits [7:0] and clears `cmp_en_o`. No match can occur until the top byte is written, even when the timer equals the partly updated value.
- R10: In an instance whose `SLOT_IDX` differs from `WDOG_IDX`, `int_rst_o` and `wdog_en_o` stay zero whatever is written.
- R11: If the timer stays equal to the compare value for several cycles, only one `match_o` pulse is produced.
- R12: If a byte write and a `cfg_we_i` write arrive in the same cycle, the byte write decides `cmp_en_o`: a low byte clears it and the top byte sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| timer_i | input | TMR_W | Shared free-running timer value |
| wr_en_i | input | 1 | Compare byte write strobe |
| wr_sel_i | input | SEL_W | Byte lane of the write, 0 = least significant |
| wr_data_i | input | BYTE_W | Byte to store |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cmp_en_i | input | 1 | Comparator enable value to load |
| cfg_wdog_en_i | input | 1 | Watchdog enable value to load |
| cmp_val_o | output | TMR_W | Current compare value |
| cmp_en_o | output | 1 | Comparator enable |
| wdog_en_o | output | 1 | Watchdog armed |
| match_o | output | 1 | One-cycle compare match flag |
| int_rst_o | output | 1 | One-cycle internal reset request |

## Verification
On every cycle the assertions check the pulse shapes of the match and reset outputs, and that a reset only ever follows an armed cycle and a match. They also check that the registers are already cleared in the firing cycle, that lane writes move the comparator enable, and that a slot other than the watchdog slot never fires. Only the bench scenarios can show that the flag appears at the right timer value and at no other value across whole sweeps. The same applies to the two hold-off strategies, to disarming and re-arming, to a write being discarded in the firing cycle, and to a held timer producing only one pulse.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

   typedef enum logic [1:0] {
      LANE_LOW  = 2'd0,
      LANE_MID  = 2'd1,
      LANE_TOP  = 2'd2
   } lane_role_e;

   function automatic lane_role_e lane_role(input int idx, input int n_lanes);
      if (idx == 0)           return LANE_LOW;
      if (idx == n_lanes - 1) return LANE_TOP;
      return LANE_MID;
   endfunction

   function automatic int sel_width(input int n_lanes);
      return (n_lanes > 1) ? $clog2(n_lanes) : 1;
   endfunction

endpackage

// File: rtl/cwd_cmp_bank.sv
module cwd_cmp_bank
   import cwd_pkg::*;
#(
   parameter int TMR_W  = 16,
   parameter int BYTE_W = 8,
   localparam int N_LANES = TMR_W / BYTE_W,
   localparam int SEL_W   = sel_width(N_LANES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              wr_en_i,
   input  logic [SEL_W-1:0]  wr_sel_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              wr_low_i,
   input  logic              wr_top_i,
   input  logic              cfg_we_i,
   input  logic              cfg_cmp_en_i,
   output logic [TMR_W-1:0]  val_o,
   output logic              en_o
);

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
      logic [BYTE_W-1:0] lane_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni || clr_i) begin
            lane_q <= '0;
         end else if (wr_en_i && (wr_sel_i == MY_SEL)) begin
            lane_q <= wr_data_i;
         end
      end

      assign val_o[g*BYTE_W +: BYTE_W] = lane_q;
   end

   logic en_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) begin
         en_q <= 1'b0;
      end else if (wr_low_i) begin
         en_q <= 1'b0;
      end else if (wr_top_i) begin
         en_q <= 1'b1;
      end else if (cfg_we_i) begin
         en_q <= cfg_cmp_en_i;
      end
   end

   assign en_o = en_q;

endmodule

// File: rtl/cwd_match.sv
module cwd_match #(
   parameter int TMR_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [TMR_W-1:0] timer_i,
   input  logic [TMR_W-1:0] val_i,
   input  logic             en_i,
   output logic             edge_o,
   output logic             match_o
);

   logic hit_c;
   logic hit_prev_q;
   logic match_q;

   assign hit_c  = en_i && (timer_i == val_i);
   assign edge_o = hit_c && !hit_prev_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         hit_prev_q <= 1'b0;
         match_q    <= 1'b0;
      end else begin
         hit_prev_q <= hit_c;
         match_q    <= edge_o;
      end
   end

   assign match_o = match_q;

endmodule

// File: rtl/cwd_arm.sv
module cwd_arm #(
   parameter bit IS_WDOG = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic edge_i,
   input  logic cfg_we_i,
   input  logic cfg_wdog_en_i,
   output logic fire_o,
   output logic wdog_en_o,
   output logic int_rst_o
);

   if (IS_WDOG) begin : g_wdog
      logic armed_q;
      logic rst_q;

      assign fire_o = edge_i && armed_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            armed_q <= 1'b0;
            rst_q   <= 1'b0;
         end else begin
            rst_q <= fire_o;
            if (fire_o) begin
               armed_q <= 1'b0;
            end else if (cfg_we_i) begin
               armed_q <= cfg_wdog_en_i;
            end
         end
      end

      assign wdog_en_o = armed_q;
      assign int_rst_o = rst_q;
   end else begin : g_plain
      logic unused_c;
      assign unused_c  = clk_i ^ rst_ni ^ edge_i ^ cfg_we_i ^ cfg_wdog_en_i;
      assign fire_o    = 1'b0;
      assign wdog_en_o = 1'b0;
      assign int_rst_o = 1'b0 & unused_c;
   end

endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog
   import cwd_pkg::*;
#(
   parameter int TMR_W    = 16,
   parameter int BYTE_W   = 8,
   parameter int N_SLOTS  = 5,
   parameter int WDOG_IDX = 4,
   parameter int SLOT_IDX = 4,
   localparam int N_LANES = TMR_W / BYTE_W,
   localparam int SEL_W   = sel_width(N_LANES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [TMR_W-1:0]  timer_i,
   input  logic              wr_en_i,
   input  logic [SEL_W-1:0]  wr_sel_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              cfg_we_i,
   input  logic              cfg_cmp_en_i,
   input  logic              cfg_wdog_en_i,
   output logic [TMR_W-1:0]  cmp_val_o,
   output logic              cmp_en_o,
   output logic              wdog_en_o,
   output logic              match_o,
   output logic              int_rst_o
);

   localparam bit IS_WDOG = (SLOT_IDX == WDOG_IDX);
   localparam logic [SEL_W-1:0] LOW_SEL = '0;
   localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(N_LANES - 1);

   if (TMR_W % BYTE_W != 0) begin : g_bad_width
      $error("TMR_W must be a whole number of BYTE_W lanes");
   end
   if (N_LANES < 2) begin : g_bad_lanes
      $error("compare value needs at least two byte lanes");
   end
   if (WDOG_IDX < 0 || WDOG_IDX >= N_SLOTS) begin : g_bad_wdog
      $error("WDOG_IDX outside the slot array");
   end
   if (SLOT_IDX < 0 || SLOT_IDX >= N_SLOTS) begin : g_bad_slot
      $error("SLOT_IDX outside the slot array");
   end

   logic wr_low_c;
   logic wr_top_c;
   logic edge_c;
   logic fire_c;

   assign wr_low_c = wr_en_i && (wr_sel_i == LOW_SEL);
   assign wr_top_c = wr_en_i && (wr_sel_i == TOP_SEL);

   cwd_cmp_bank #(
      .TMR_W  (TMR_W),
      .BYTE_W (BYTE_W)
   ) u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (fire_c),
      .wr_en_i      (wr_en_i),
      .wr_sel_i     (wr_sel_i),
      .wr_data_i    (wr_data_i),
      .wr_low_i     (wr_low_c),
      .wr_top_i     (wr_top_c),
      .cfg_we_i     (cfg_we_i),
      .cfg_cmp_en_i (cfg_cmp_en_i),
      .val_o        (cmp_val_o),
      .en_o         (cmp_en_o)
   );

   cwd_match #(
      .TMR_W (TMR_W)
   ) u_match (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .timer_i (timer_i),
      .val_i   (cmp_val_o),
      .en_i    (cmp_en_o),
      .edge_o  (edge_c),
      .match_o (match_o)
   );

   cwd_arm #(
      .IS_WDOG (IS_WDOG)
   ) u_arm (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .edge_i        (edge_c),
      .cfg_we_i      (cfg_we_i),
      .cfg_wdog_en_i (cfg_wdog_en_i),
      .fire_o        (fire_c),
      .wdog_en_o     (wdog_en_o),
      .int_rst_o     (int_rst_o)
   );

endmodule

// File: rtl/cmp_watchdog_chk.sv
module cmp_watchdog_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic is_wdog_i,
   input logic wr_low_i,
   input logic wr_top_i,
   input logic cmp_zero_i,
   input logic cmp_en_i,
   input logic wdog_en_i,
   input logic match_i,
   input logic int_rst_i
);

   AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_rst_i |=> !int_rst_i); // R4
   AST_RST_WITH_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_rst_i |-> match_i); // R4
   AST_RST_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_rst_i |-> $past(wdog_en_i)); // R6
   AST_FIRE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_rst_i |-> (cmp_zero_i && !cmp_en_i && !wdog_en_i)); // R5
   AST_MATCH_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i |-> $past(cmp_en_i)); // R3
   AST_MATCH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_i |=> !match_i); // R11
   AST_LOW_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_low_i |=> !cmp_en_i); // R9
   AST_HIGH_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_top_i |=> (cmp_en_i || int_rst_i)); // R2
   AST_SLOT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_wdog_i |-> (!int_rst_i && !wdog_en_i)); // R10

endmodule

bind cmp_watchdog cmp_watchdog_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .is_wdog_i  (IS_WDOG),
   .wr_low_i   (wr_low_c),
   .wr_top_i   (wr_top_c),
   .cmp_zero_i (~|cmp_val_o),
   .cmp_en_i   (cmp_en_o),
   .wdog_en_i  (wdog_en_o),
   .match_i    (match_o),
   .int_rst_i  (int_rst_o)
);

// File: tb/sim_cmp_watchdog.sv
module sim_cmp_watchdog;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] timer = '0;
   logic        wr_en = 1'b0;
   logic [0:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        cfg_we = 1'b0;
   logic        cfg_cmp_en = 1'b0;
   logic        cfg_wdog_en = 1'b0;

   logic [15:0] val0, val1;
   logic        en0, en1, wd0, wd1, m0, m1, r0, r1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cmp_watchdog u0 (
      .clk_i (clk), .rst_ni (rst_n), .timer_i (timer),
      .wr_en_i (wr_en), .wr_sel_i (wr_sel), .wr_data_i (wr_data),
      .cfg_we_i (cfg_we), .cfg_cmp_en_i (cfg_cmp_en), .cfg_wdog_en_i (cfg_wdog_en),
      .cmp_val_o (val0), .cmp_en_o (en0), .wdog_en_o (wd0),
      .match_o (m0), .int_rst_o (r0)
   );

   cmp_watchdog #(.SLOT_IDX(2)) u1 (
      .clk_i (clk), .rst_ni (rst_n), .timer_i (timer),
      .wr_en_i (wr_en), .wr_sel_i (wr_sel), .wr_data_i (wr_data),
      .cfg_we_i (cfg_we), .cfg_cmp_en_i (cfg_cmp_en), .cfg_wdog_en_i (cfg_wdog_en),
      .cmp_val_o (val1), .cmp_en_o (en1), .wdog_en_o (wd1),
      .match_o (m1), .int_rst_o (r1)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      chk({31'd0, r1}, 32'd0, "R10 other slot reset");
      chk({31'd0, wd1}, 32'd0, "R10 other slot armed");
   endtask

   task automatic wr_byte(input bit sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic cfg(input bit ce, input bit we);
      cfg_we = 1'b1; cfg_cmp_en = ce; cfg_wdog_en = we;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic load(input logic [15:0] c);
      wr_byte(1'b0, c[7:0]);
      wr_byte(1'b1, c[15:8]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] cases [4];
      cases[0] = 16'h0000; cases[1] = 16'h00FF; cases[2] = 16'h0100; cases[3] = 16'h01FF;

      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      step();
      chk(val0, 0, "R1 compare value");
      chk(en0, 0, "R1 comparator enable");
      chk(wd0, 0, "R1 watchdog enable");
      chk(m0, 0, "R1 match");
      chk(r0, 0, "R1 reset out");

      // R2 / R9: lane writes and enable side effects
      timer = 16'hFFFF;
      wr_byte(1'b1, 8'hA5);
      chk(val0, 16'hA500, "R2 top lane value");
      chk(en0, 1, "R2 top lane sets enable");
      wr_byte(1'b0, 8'h3C);
      chk(val0, 16'hA53C, "R9 low lane value");
      chk(en0, 0, "R9 low lane clears enable");
      cfg(1'b1, 1'b0);
      chk(en0, 1, "R2 cfg sets enable");
      cfg(1'b0, 1'b0);
      chk(en0, 0, "R2 cfg clears enable");

      // R3: timer sweeps against boundary compare values, watchdog off
      foreach (cases[k]) begin
         timer = 16'hFFFF;
         load(cases[k]);
         for (int t = 0; t < 512; t++) begin
            timer = 16'(t);
            step();
            chk(m0, (16'(t) == cases[k]), "R3 match sweep");
            chk(r0, 0, "R6 no reset while disarmed");
         end
      end

      // R3: no match with comparator disabled
      cfg(1'b0, 1'b0);
      for (int t = 0; t < 512; t++) begin
         timer = 16'(t);
         step();
         chk(m0, 0, "R3 no match while disabled");
      end

      // R11: held equality produces one pulse
      timer = 16'hFFFF;
      load(16'h0200);
      timer = 16'h0200;
      for (int i = 0; i < 5; i++) begin
         step();
         chk(m0, (i == 0), "R11 single pulse on held timer");
      end

      // R9: half-updated value never matches
      timer = 16'hFFFF;
      load(16'h1234);
      wr_byte(1'b0, 8'h56);
      timer = 16'h1256;
      for (int i = 0; i < 3; i++) begin
         step();
         chk(m0, 0, "R9 no match on half update");
      end
      wr_byte(1'b1, 8'h12);
      chk(m0, 0, "R9 enable just set");
      step();
      chk(m0, 1, "R9 match after top lane");

      // R4 / R5: armed sweep, write in firing cycle discarded
      timer = 16'hFFFF;
      load(16'h0150);
      cfg(1'b1, 1'b1);
      chk(wd0, 1, "R7 armed");
      for (int t = 16'h0140; t <= 16'h0160; t++) begin
         timer = 16'(t);
         if (t == 16'h0150) begin
            wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hAB;
         end
         step();
         wr_en = 1'b0;
         chk(r0, (t == 16'h0150), "R4 reset at match");
         chk(m0, (t == 16'h0150), "R4 match with reset");
         if (t == 16'h0150) begin
            chk(val0, 0, "R5 compare cleared");
            chk(en0, 0, "R5 enable cleared");
            chk(wd0, 0, "R5 watchdog cleared");
         end
      end

      // R6 / R7: disarm before match, then re-arm
      timer = 16'hFFFF;
      load(16'h0020);
      cfg(1'b1, 1'b1);
      for (int t = 16'h10; t <= 16'h20; t++) begin
         timer = 16'(t);
         if (t == 16'h1F) begin
            cfg_we = 1'b1; cfg_cmp_en = 1'b1; cfg_wdog_en = 1'b0;
         end
         step();
         cfg_we = 1'b0;
         chk(m0, (t == 16'h20), "R6 match while disarmed");
         chk(r0, 0, "R6 disarmed no reset");
      end
      timer = 16'hFFFF;
      cfg(1'b1, 1'b1);
      for (int t = 16'h18; t <= 16'h21; t++) begin
         timer = 16'(t);
         step();
         chk(r0, (t == 16'h20), "R7 re-armed fires");
      end

      // R8: move compare ahead, and timer rewrite
      timer = 16'hFFFF;
      load(16'd100);
      cfg(1'b1, 1'b1);
      for (int t = 0; t < 90; t++) begin
         timer = 16'(t);
         step();
         chk(r0, 0, "R8 before move");
      end
      timer = 16'd90;
      load(16'd200);
      for (int t = 91; t <= 200; t++) begin
         timer = 16'(t);
         step();
         chk(r0, (t == 200), "R8 moved compare");
      end
      timer = 16'hFFFF;
      load(16'h0040);
      cfg(1'b1, 1'b1);
      for (int w = 0; w < 3; w++) begin
         for (int t = 0; t < 16'h40; t++) begin
            timer = 16'(t);
            step();
            chk(r0, 0, "R8 timer rewrite holds off");
         end
      end
      chk(wd0, 1, "R8 still armed");

      // R12: byte write wins over cfg write
      timer = 16'hFFFF;
      load(16'h0300);
      cfg_we = 1'b1; cfg_cmp_en = 1'b1; cfg_wdog_en = 1'b0;
      wr_byte(1'b0, 8'h01);
      cfg_we = 1'b0;
      chk(en0, 0, "R12 low lane beats cfg");
      cfg_we = 1'b1; cfg_cmp_en = 1'b0; cfg_wdog_en = 1'b0;
      wr_byte(1'b1, 8'h03);
      cfg_we = 1'b0;
      chk(en0, 1, "R12 top lane beats cfg");
      chk(val0, 16'h0301, "R12 value");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule